// File: doc/BRIEF.md
# Two-Stage Periodic Tick Timer

This block makes periodic time-out events from the bus clock in two stages. Two 8-bit micro timers count down and reload on their own. Each acts as a reloadable prescaler. Four 16-bit channel counters each follow one micro timer, which a per-channel select bit picks. A channel moves down one step each time its micro timer wraps through zero.

When a channel wraps through zero, it does four things:
- It reloads from its load value.
- It sets a sticky time-out flag.
- It pulses its tick output for one clock.
- It raises its interrupt line if that channel is enabled.

Software drives the block through a small word-wide register port. Through it, software:
- sets the load values;
- picks the micro timer for each channel;
- restarts any mix of micro timers and channels with a single write;
- clears flags by writing ones;
- reads back the live channel counts.

The micro-timer counts cannot be read. One global run bit gates all counting. While that bit is clear, every counter holds its load value. With micro load M and channel load L, the time-out period is (M+1)·(L+1) clocks. At a 40 MHz clock the longest period is 256·65536·25 ns, about 419.43 ms.

Top module: `periodicTickTimer`

## Requirements
- R1: With run set, a channel with load L following a micro timer with load M times out every (M+1)·(L+1) clocks. The first time-out comes that many clocks after the write that sets run. Each time-out drives that channel's `tickOut` bit high for exactly the clock after the expiring edge.
- R2: Bit c of the select register at address 0x04 picks the micro timer for channel c. A value of 0 selects micro timer 0 and a value of 1 selects micro timer 1.
- R3: Reading address 0x18+c returns channel c's live count. After k clocks of running, the count is L − (⌊k/(M+1)⌋ mod (L+1)). The count reloads to L after it reaches zero.
- R4: Bit c of the flag register at address 0x02 becomes 1 at each time-out of channel c. It stays 1 until software writes a 1 to that bit. If a set and a clear fall in the same clock, the set wins.
- R5: `irqOut[c]` is 1 exactly when flag c and enable bit c of the register at address 0x03 are both 1.
- R6: A write to address 0x01 restarts the selected counters from their load values in the clock of the write. Bits [3:0] select channels and bits [9:8] select micro timers. A counter restarted this way does not expire in that clock.
- R7: Bit 0 at address 0x00 is the run bit. While it is 0, every counter is loaded with its load value each clock and no time-out occurs.
- R8: After reset the following are all zero: run, loads, selects, enables, flags, counts, `tickOut` and `irqOut`.
- R9: The micro-timer load values are written at address 0x08+m. The channel load values are written at address 0x10+c. Both read back at the same addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for `regAddr`, combinational |
| tickOut | output | 4 | Per-channel one-clock time-out pulse |
| irqOut | output | 4 | Per-channel interrupt request |

## Verification
The bench builds the block with its default widths: four channels, two micro timers, 8-bit micro counters and 16-bit channel counters. It programs only small load values, so every period lies between 1 and 12 clocks. The sweep covers micro loads 0 to 2 and 0 to 1, channel loads 0 to 3, and both select settings. Each tick, interrupt line and read-back count is then compared with its arithmetic expectation on every clock over several full periods. Restart, clear and disable are each checked against periods short enough to observe exactly.

// File: rtl/tickTimerPkg.sv
package tickTimerPkg;
  localparam int CH_N   = 4;
  localparam int MT_N   = 2;
  localparam int SEL_W  = (MT_N > 1) ? $clog2(MT_N) : 1;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'h00;
  localparam logic [ADDR_W-1:0] A_RESTART = 5'h01;
  localparam logic [ADDR_W-1:0] A_FLAG    = 5'h02;
  localparam logic [ADDR_W-1:0] A_IRQEN   = 5'h03;
  localparam logic [ADDR_W-1:0] A_SEL     = 5'h04;
  localparam logic [ADDR_W-1:0] A_MTLD    = 5'h08;
  localparam logic [ADDR_W-1:0] A_CHLD    = 5'h10;
  localparam logic [ADDR_W-1:0] A_CHCNT   = 5'h18;

  localparam int MT_FORCE_LSB = 8;

  typedef struct packed {
    logic [CH_N-1:0] chForce;
    logic [MT_N-1:0] mtForce;
    logic [CH_N-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/tickTimerCtrl.sv
module tickTimerCtrl
  import tickTimerPkg::*;
#(
  parameter int MT_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWr,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [15:0]                 regWdata,
  output logic [15:0]                 regRdata,
  input  logic [CH_N-1:0]             flags,
  input  logic [CH_N-1:0][CNT_W-1:0]  chCnt,
  output logic                        runEn,
  output logic [CH_N-1:0]             irqEn,
  output logic [CH_N*SEL_W-1:0]       chSel,
  output logic [MT_N-1:0][MT_W-1:0]   mtLoad,
  output logic [CH_N-1:0][CNT_W-1:0]  chLoad,
  output strobe_t                     stb
);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn  <= 1'b0;
      irqEn  <= '0;
      chSel  <= '0;
      mtLoad <= '0;
      chLoad <= '0;
    end else if (regWr) begin
      if (regAddr == A_CTRL)  runEn <= regWdata[0];
      if (regAddr == A_IRQEN) irqEn <= regWdata[CH_N-1:0];
      if (regAddr == A_SEL)   chSel <= regWdata[CH_N*SEL_W-1:0];
      for (int m = 0; m < MT_N; m++)
        if (regAddr == A_MTLD + ADDR_W'(m)) mtLoad[m] <= regWdata[MT_W-1:0];
      for (int c = 0; c < CH_N; c++)
        if (regAddr == A_CHLD + ADDR_W'(c)) chLoad[c] <= regWdata[CNT_W-1:0];
    end
  end

  // same-cycle strobes towards the datapath
  always_comb begin
    stb = '0;
    if (regWr && regAddr == A_RESTART) begin
      stb.chForce = regWdata[CH_N-1:0];
      stb.mtForce = regWdata[MT_FORCE_LSB +: MT_N];
    end
    if (regWr && regAddr == A_FLAG)
      stb.flagClr = regWdata[CH_N-1:0];
  end

  // read mux
  always_comb begin
    regRdata = '0;
    if (regAddr == A_CTRL)  regRdata[0] = runEn;
    if (regAddr == A_FLAG)  regRdata[CH_N-1:0] = flags;
    if (regAddr == A_IRQEN) regRdata[CH_N-1:0] = irqEn;
    if (regAddr == A_SEL)   regRdata[CH_N*SEL_W-1:0] = chSel;
    for (int m = 0; m < MT_N; m++)
      if (regAddr == A_MTLD + ADDR_W'(m)) regRdata[MT_W-1:0] = mtLoad[m];
    for (int c = 0; c < CH_N; c++) begin
      if (regAddr == A_CHLD + ADDR_W'(c))  regRdata[CNT_W-1:0] = chLoad[c];
      if (regAddr == A_CHCNT + ADDR_W'(c)) regRdata[CNT_W-1:0] = chCnt[c];
    end
  end

endmodule

// File: rtl/tickTimerCore.sv
module tickTimerCore
  import tickTimerPkg::*;
#(
  parameter int MT_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        runEn,
  input  logic [CH_N*SEL_W-1:0]       chSel,
  input  logic [MT_N-1:0][MT_W-1:0]   mtLoad,
  input  logic [CH_N-1:0][CNT_W-1:0]  chLoad,
  input  strobe_t                     stb,
  output logic [CH_N-1:0][CNT_W-1:0]  chCnt,
  output logic [CH_N-1:0]             flags,
  output logic [CH_N-1:0]             tickOut
);

  logic [MT_N-1:0] mtWrap;

  // prescaler stage
  for (genvar m = 0; m < MT_N; m++) begin : g_mt
    logic [MT_W-1:0] mtCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        mtCnt <= '0;
      else if (!runEn || stb.mtForce[m]) mtCnt <= mtLoad[m];
      else if (mtCnt == '0)             mtCnt <= mtLoad[m];
      else                              mtCnt <= mtCnt - 1'b1;
    end

    assign mtWrap[m] = runEn && !stb.mtForce[m] && (mtCnt == '0);
  end

  // channel stage
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cnt;
    logic             flag;
    logic             pulse;

    always_comb begin
      tick = 1'b0;
      for (int m = 0; m < MT_N; m++)
        if (chSel[c*SEL_W +: SEL_W] == SEL_W'(m)) tick = mtWrap[m];
    end

    assign expire = tick && !stb.chForce[c] && (cnt == '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt   <= '0;
        flag  <= 1'b0;
        pulse <= 1'b0;
      end else begin
        if (!runEn || stb.chForce[c]) cnt <= chLoad[c];
        else if (tick)                cnt <= (cnt == '0) ? chLoad[c] : cnt - 1'b1;
        if (expire)                flag <= 1'b1;
        else if (stb.flagClr[c])   flag <= 1'b0;
        pulse <= expire;
      end
    end

    assign chCnt[c]   = cnt;
    assign flags[c]   = flag;
    assign tickOut[c] = pulse;
  end

endmodule

// File: rtl/periodicTickTimer.sv
module periodicTickTimer
  import tickTimerPkg::*;
#(
  parameter int MT_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic [CH_N-1:0]   tickOut,
  output logic [CH_N-1:0]   irqOut
);

  logic                       runEn;
  logic [CH_N-1:0]            irqEn;
  logic [CH_N*SEL_W-1:0]      chSel;
  logic [MT_N-1:0][MT_W-1:0]  mtLoad;
  logic [CH_N-1:0][CNT_W-1:0] chLoad;
  logic [CH_N-1:0][CNT_W-1:0] chCnt;
  logic [CH_N-1:0]            flags;
  strobe_t                    stb;

  tickTimerCtrl #(.MT_W(MT_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .flags(flags), .chCnt(chCnt),
    .runEn(runEn), .irqEn(irqEn), .chSel(chSel), .mtLoad(mtLoad),
    .chLoad(chLoad), .stb(stb)
  );

  tickTimerCore #(.MT_W(MT_W), .CNT_W(CNT_W)) i_core (
    .clk(clk), .rstN(rstN), .runEn(runEn), .chSel(chSel), .mtLoad(mtLoad),
    .chLoad(chLoad), .stb(stb), .chCnt(chCnt), .flags(flags), .tickOut(tickOut)
  );

  assign irqOut = flags & irqEn;

endmodule

// File: rtl/tickTimerChk.sv
module tickTimerChk
  import tickTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       runEn,
  input logic [CH_N-1:0][CNT_W-1:0] chCnt,
  input logic [CH_N-1:0][CNT_W-1:0] chLoad,
  input logic [CH_N-1:0]            chForce,
  input logic [CH_N-1:0]            flags,
  input logic [CH_N-1:0]            irqEn,
  input logic [CH_N-1:0]            tickOut,
  input logic [CH_N-1:0]            irqOut
);

  for (genvar c = 0; c < CH_N; c++) begin : g_chk
    // R1
    tick_from_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickOut[c] |-> ($past(chCnt[c]) == '0));
    // R4
    flag_with_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
      tickOut[c] |-> flags[c]);
    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flags[c]) |-> tickOut[c]);
    // R5
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqOut[c] |-> (flags[c] && irqEn[c]));
    // R6
    restart_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      chForce[c] |=> (chCnt[c] == $past(chLoad[c]) && !tickOut[c]));
    // R7
    idle_load_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runEn |=> (chCnt[c] == $past(chLoad[c])));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runEn |=> !tickOut[c]);
  end

endmodule

bind periodicTickTimer tickTimerChk #(.CNT_W(CNT_W)) i_tickTimerChk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .chCnt(chCnt), .chLoad(chLoad),
  .chForce(stb.chForce), .flags(flags), .irqEn(irqEn), .tickOut(tickOut),
  .irqOut(irqOut)
);

// File: tb/test_periodicTickTimer.sv
`timescale 1ns/1ps
module test_periodicTickTimer;
  import tickTimerPkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [15:0]       regWdata = '0;
  logic [15:0]       regRdata;
  logic [CH_N-1:0]   tickOut;
  logic [CH_N-1:0]   irqOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  periodicTickTimer i_periodicTickTimer (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .tickOut(tickOut), .irqOut(irqOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns on the falling edge right after the write edge
  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = ADDR_W'(a); regWdata = 16'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    regAddr = ADDR_W'(a);
    #0.5;
    v = int'(regRdata);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int v;
    int mt[2];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    check("R8 tickOut", int'(tickOut), 0);
    check("R8 irqOut", int'(irqOut), 0);
    rd(A_CTRL, v);  check("R8 run", v, 0);
    rd(A_FLAG, v);  check("R8 flags", v, 0);
    rd(A_IRQEN, v); check("R8 irqEn", v, 0);
    rd(A_SEL, v);   check("R8 select", v, 0);
    for (int c = 0; c < CH_N; c++) begin
      rd(int'(A_CHCNT) + c, v); check("R8 count", v, 0);
      rd(int'(A_CHLD) + c, v);  check("R8 load", v, 0);
    end

    // sweep of micro loads, channel loads 0..3, channels 1 and 3 on micro 1
    for (int m0 = 0; m0 < 3; m0++) begin
      for (int m1 = 0; m1 < 2; m1++) begin
        mt[0] = m0; mt[1] = m1;
        wr(A_CTRL, 0);
        wr(A_MTLD, m0);
        wr(int'(A_MTLD) + 1, m1);
        for (int c = 0; c < CH_N; c++) wr(int'(A_CHLD) + c, c);
        wr(A_SEL, 'b1010);
        wr(A_IRQEN, 'b0101);
        wr(A_FLAG, 'hF);
        // R9 load read-back
        rd(A_MTLD, v); check("R9 micro load 0", v, m0);
        rd(int'(A_MTLD) + 1, v); check("R9 micro load 1", v, m1);
        rd(A_SEL, v); check("R2 select read-back", v, 'b1010);
        // R7 idle counters hold load values
        for (int c = 0; c < CH_N; c++) begin
          rd(int'(A_CHCNT) + c, v); check("R7 idle count", v, c);
        end
        wr(A_CTRL, 1);
        for (int k = 0; k < 48; k++) begin
          int rc, rsel;
          if (k > 0) @(negedge clk);
          for (int c = 0; c < CH_N; c++) begin
            int p, et, ei;
            p  = (mt[c % 2] + 1) * (c + 1);
            et = (k > 0 && k % p == 0) ? 1 : 0;
            ei = (k >= p && c % 2 == 0) ? 1 : 0;
            check("R1 R2 tick", int'(tickOut[c]), et);
            check("R5 irq", int'(irqOut[c]), ei);
          end
          rc = k % CH_N;
          rsel = rc % 2;
          rd(int'(A_CHCNT) + rc, v);
          check("R3 count", v, rc - ((k / (mt[rsel] + 1)) % (rc + 1)));
        end
        wr(A_CTRL, 0);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          check("R7 no tick while idle", int'(tickOut), 0);
          rd(int'(A_CHCNT) + (k % CH_N), v);
          check("R7 idle reload", v, k % CH_N);
          @(negedge clk);
        end
        rd(A_FLAG, v); check("R4 sticky flags", v, 'hF);
        wr(A_FLAG, 'b0011);
        rd(A_FLAG, v); check("R4 write-one-to-clear", v, 'b1100);
        check("R5 irq after clear", int'(irqOut), 'b0100);
      end
    end

    // R6 joint restart of micro 0 and channel 0, period 12
    wr(A_CTRL, 0);
    wr(A_MTLD, 2);
    wr(A_CHLD, 3);
    wr(A_SEL, 0);
    wr(A_FLAG, 'hF);
    wr(A_CTRL, 1);
    repeat (7) @(negedge clk);
    wr(A_RESTART, 'h0101);
    for (int k = 0; k < 26; k++) begin
      if (k > 0) @(negedge clk);
      check("R6 joint restart tick", int'(tickOut[0]), (k > 0 && k % 12 == 0) ? 1 : 0);
    end

    // R6 channel-only restart, micro wraps every clock, period 6
    wr(A_CTRL, 0);
    wr(A_MTLD, 0);
    wr(A_CHLD, 5);
    wr(A_CTRL, 1);
    repeat (3) @(negedge clk);
    wr(A_RESTART, 'h0001);
    rd(A_CHCNT, v); check("R6 count after restart", v, 5);
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      check("R6 channel restart tick", int'(tickOut[0]), (k > 0 && k % 6 == 0) ? 1 : 0);
    end

    summary();
    $finish;
  end

endmodule